// File: doc/BRIEF.md
# LIN slave header receiver

This block is the slave-side front end of a LIN node. It watches the single-wire receive line at a fixed bit rate. A clock-enable tick supplied from outside arrives sixteen times per bit. The block finds the break field, then takes in the sync byte and the protected identifier byte. When the header is clean it hands the 6-bit frame identifier to the response logic, together with a one-cycle strobe.

Five sticky error flags and an interrupt report anything that went wrong: bit framing, break length, sync value, identifier parity and bus inactivity. Any error sends the receiver back to waiting for a new break. Software clears a flag by pulsing its bit on a write-one-to-clear input.

The controller is built around one state machine with four states:
- `S_IDLE` waits for the line to go low.
- `S_BRK` counts how long the line stays low.
- `S_WAIT` waits for the falling edge that starts the next byte.
- `S_RX` is active while a byte is being received.

Its transitions are as follows:
- Idle to break, on a low sample.
- Break to wait, when the low lasted at least 13 bit times.
- Break to idle, when the low was too short. If that low lasted 10 or more bit times, a break error is also raised.
- Wait to receive, on a falling edge.
- Receive to wait, after a good sync byte.
- Receive to idle, on a header accept or on any error.
- Wait or receive to idle, on a timeout.

Top module: `lin_hdr_rx`

## Requirements
- R1: A low period is taken as a break only when it lasts at least 13 bit times (208 ticks). A low period shorter than 10 bit times in the idle state raises no flag and produces no header.
- R2: A low period of at least 10 but fewer than 13 bit times sets the break error flag, `err_flags[1]`.
- R3: Every byte after the break is 10 bits long: a start bit, 8 data bits sent least significant bit first, and a stop bit. A start bit that is not low, or a stop bit that is not high, sets the bit error flag, `err_flags[0]`.
- R4: The first byte after the break must be 0x55. Any other value sets the sync error flag, `err_flags[2]`.
- R5: The second byte carries the identifier in bits 5..0, with parity P0 in bit 6 and P1 in bit 7. P0 = ID0^ID1^ID2^ID4 and P1 = NOT(ID1^ID3^ID4^ID5). A mismatch sets the parity error flag, `err_flags[3]`.
- R6: A clean header gives exactly one one-cycle `hdr_valid` pulse, with `frame_id` equal to bits 5..0 of the identifier byte.
- R7: The gap between bytes is not timed. The next byte starts on the first falling edge after the previous stop bit, however late that edge comes.
- R8: Each bit takes the majority of the samples at ticks 7, 8 and 9 of its 16. A glitch covering one sample does not change the bit.
- R9: After a break has been recognized, a run of `to_limit` ticks with no line edge sets the timeout flag, `err_flags[4]`. A `to_limit` of 0 turns the timeout off.
- R10: Error flags stay set until cleared. Writing 1 to an `err_clr` bit clears only that flag. `irq` is high exactly when any flag is set.
- R11: After any error the receiver goes back to waiting for a break, so bytes that follow an error produce no header.
- R12: After reset, `err_flags`, `irq`, `hdr_valid` and `frame_id` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | Sample enable, 16 per bit time |
| rx_in | input | 1 | LIN receive line, idle high |
| to_limit | input | TO_W | Inactivity limit in ticks, 0 disables |
| err_clr | input | 5 | Write-one-to-clear for the error flags |
| frame_id | output | 6 | Identifier of the last accepted header |
| hdr_valid | output | 1 | One-cycle strobe on header accept |
| err_flags | output | 5 | Sticky flags: bit, break, sync, parity, timeout |
| irq | output | 1 | High while any flag is set |

## Verification
The `hdr_valid` strobe and the bit, sync and parity flags register one clock after the tick at sample 9 of the stop bit. For the identifier byte that is about 9.5 bit times after its start edge. The break error registers one clock after the first high tick that ends the low period. The timeout flag registers one clock after the `to_limit`-th tick without an edge.

The bench reads results three idle bit times after each frame, which is well past every one of these points. The timeout test brackets the expected moment: the flag must still be clear 10 bit times after the break ends and must be set at 14 bit times. Flag clearing is checked two clocks after the `err_clr` pulse.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BRK,
        S_WAIT,
        S_RX
    } hdr_state_e;

    typedef enum logic {
        FLD_SYNC,
        FLD_PID
    } fld_e;

    localparam int ERR_N    = 5;
    localparam int ERR_BIT  = 0;
    localparam int ERR_BRK  = 1;
    localparam int ERR_SYNC = 2;
    localparam int ERR_PAR  = 3;
    localparam int ERR_TMO  = 4;

    localparam logic [7:0] SYNC_VAL = 8'h55;

    // returns {p1, p0} for a 6-bit identifier
    function automatic logic [1:0] pid_parity(input logic [5:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0};
    endfunction

endpackage

// File: rtl/lin_line_sampler.sv
module lin_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic rx_s,
    output logic fall_tk,
    output logic edge_tk
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
            if (tick) begin
                prev_q <= rx_s;
            end
        end
    end

    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign fall_tk = tick & prev_q & ~rx_s;
    assign edge_tk = tick & (prev_q ^ rx_s);

endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       start,
    input  logic       run,
    output logic       done,
    output logic [7:0] data,
    output logic       start_lvl,
    output logic       stop_lvl
);

    localparam int PH_W = $clog2(OSR);
    localparam int BITS = 10;
    localparam int BI_W = $clog2(BITS);
    localparam int MID  = OSR / 2;

    localparam logic [PH_W-1:0] PH_EARLY = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_MID   = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_LATE  = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(OSR - 1);
    localparam logic [BI_W-1:0] BI_STOP  = BI_W'(BITS - 1);

    logic [PH_W-1:0] ph_q;
    logic [BI_W-1:0] bi_q;
    logic            s_early_q;
    logic            s_mid_q;
    logic            done_q;
    logic [7:0]      data_q;
    logic            start_lvl_q;
    logic            stop_lvl_q;
    logic            vote;

    assign vote = (s_early_q & s_mid_q) | (s_early_q & rx_s) | (s_mid_q & rx_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q        <= '0;
            bi_q        <= '0;
            s_early_q   <= 1'b1;
            s_mid_q     <= 1'b1;
            done_q      <= 1'b0;
            data_q      <= '0;
            start_lvl_q <= 1'b0;
            stop_lvl_q  <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                ph_q <= PH_W'(1);
                bi_q <= '0;
            end else if (run && tick) begin
                if (ph_q == PH_LAST) begin
                    ph_q <= '0;
                    if (bi_q != BI_STOP) begin
                        bi_q <= bi_q + 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
                if (ph_q == PH_EARLY) begin
                    s_early_q <= rx_s;
                end
                if (ph_q == PH_MID) begin
                    s_mid_q <= rx_s;
                end
                if (ph_q == PH_LATE) begin
                    if (bi_q == '0) begin
                        start_lvl_q <= vote;
                    end else if (bi_q == BI_STOP) begin
                        stop_lvl_q <= vote;
                        done_q     <= 1'b1;
                    end else begin
                        data_q <= {vote, data_q[7:1]};
                    end
                end
            end
        end
    end

    assign done      = done_q;
    assign data      = data_q;
    assign start_lvl = start_lvl_q;
    assign stop_lvl  = stop_lvl_q;

    // R3
    bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bi_q < BI_W'(BITS)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/lin_idle_timer.sv
module lin_idle_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            active,
    input  logic            activity,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);

    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || activity) begin
            cnt_q <= '0;
        end else if (tick && (limit != '0) && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = active && (limit != '0) && (cnt_q == limit);

    // R9
    expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int OSR           = 16,
    parameter int BRK_BITS      = 13,
    parameter int BRK_SUSP_BITS = 10,
    parameter int TO_W          = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_tick,
    input  logic            rx_in,
    input  logic [TO_W-1:0] to_limit,
    input  logic [4:0]      err_clr,
    output logic [5:0]      frame_id,
    output logic            hdr_valid,
    output logic [4:0]      err_flags,
    output logic            irq
);

    localparam int BRK_TICKS  = BRK_BITS * OSR;
    localparam int SUSP_TICKS = BRK_SUSP_BITS * OSR;
    localparam int BRK_W      = $clog2(BRK_TICKS + 1);

    localparam logic [BRK_W-1:0] BRK_FULL = BRK_W'(BRK_TICKS);
    localparam logic [BRK_W-1:0] BRK_SUSP = BRK_W'(SUSP_TICKS);

    logic rx_s, fall_tk, edge_tk;
    logic byte_done, byte_start_lvl, byte_stop_lvl;
    logic [7:0] byte_data;
    logic byte_go, byte_run;
    logic tmo_active, tmo_hit;

    hdr_state_e       state_q, state_d;
    fld_e             fld_q, fld_d;
    logic [BRK_W-1:0] brk_q, brk_d;
    logic [ERR_N-1:0] err_set;
    logic             accept;

    logic [ERR_N-1:0] flags_q, flags_d;
    logic             irq_q;
    logic             valid_q;
    logic [5:0]       id_q;

    lin_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_tick),
        .rx_in  (rx_in),
        .rx_s   (rx_s),
        .fall_tk(fall_tk),
        .edge_tk(edge_tk)
    );

    assign byte_run = (state_q == S_RX);

    lin_byte_rx #(.OSR(OSR)) u_byte (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .rx_s     (rx_s),
        .start    (byte_go),
        .run      (byte_run),
        .done     (byte_done),
        .data     (byte_data),
        .start_lvl(byte_start_lvl),
        .stop_lvl (byte_stop_lvl)
    );

    assign tmo_active = (state_q == S_WAIT) || (state_q == S_RX);

    lin_idle_timer #(.TO_W(TO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (smp_tick),
        .active  (tmo_active),
        .activity(edge_tk),
        .limit   (to_limit),
        .expire  (tmo_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        fld_d   = fld_q;
        brk_d   = brk_q;
        err_set = '0;
        accept  = 1'b0;
        byte_go = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (smp_tick && !rx_s) begin
                    state_d = S_BRK;
                    brk_d   = BRK_W'(1);
                end
            end
            S_BRK: begin
                if (smp_tick) begin
                    if (!rx_s) begin
                        if (brk_q != BRK_FULL) begin
                            brk_d = brk_q + 1'b1;
                        end
                    end else if (brk_q >= BRK_FULL) begin
                        state_d = S_WAIT;
                        fld_d   = FLD_SYNC;
                    end else begin
                        state_d = S_IDLE;
                        if (brk_q >= BRK_SUSP) begin
                            err_set[ERR_BRK] = 1'b1;
                        end
                    end
                end
            end
            S_WAIT: begin
                if (tmo_hit) begin
                    err_set[ERR_TMO] = 1'b1;
                    state_d          = S_IDLE;
                end else if (fall_tk) begin
                    byte_go = 1'b1;
                    state_d = S_RX;
                end
            end
            S_RX: begin
                if (tmo_hit) begin
                    err_set[ERR_TMO] = 1'b1;
                    state_d          = S_IDLE;
                end else if (byte_done) begin
                    state_d = S_IDLE;
                    if (byte_start_lvl || !byte_stop_lvl) begin
                        err_set[ERR_BIT] = 1'b1;
                    end else if (fld_q == FLD_SYNC) begin
                        if (byte_data != SYNC_VAL) begin
                            err_set[ERR_SYNC] = 1'b1;
                        end else begin
                            fld_d   = FLD_PID;
                            state_d = S_WAIT;
                        end
                    end else if (pid_parity(byte_data[5:0]) != byte_data[7:6]) begin
                        err_set[ERR_PAR] = 1'b1;
                    end else begin
                        accept = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            fld_q   <= FLD_SYNC;
            brk_q   <= '0;
        end else begin
            state_q <= state_d;
            fld_q   <= fld_d;
            brk_q   <= brk_d;
        end
    end

    assign flags_d = (flags_q & ~err_clr) | err_set;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
            valid_q <= 1'b0;
            id_q    <= '0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= |flags_d;
            valid_q <= accept;
            if (accept) begin
                id_q <= byte_data[5:0];
            end
        end
    end

    assign frame_id  = id_q;
    assign hdr_valid = valid_q;
    assign err_flags = flags_q;
    assign irq       = irq_q;

    // R10
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~err_clr)) == $past(flags_q & ~err_clr)));

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (|flags_q));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R11
    err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> (state_q == S_IDLE));

endmodule

// File: tb/lin_hdr_rx_tb.sv
module lin_hdr_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLK    = 16 * TICK_DIV;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [7:0] brk;
        logic [7:0] sync;
        logic [5:0] id;
        logic       par_bad;
        logic [3:0] gap;
        logic       stop_ok;
        logic       glitch;
        logic [4:0] exp_flags;
        logic       exp_valid;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'd13, 8'h55, 6'h20, 1'b0, 4'd0, 1'b1, 1'b0, 5'h00, 1'b1},
        '{8'd20, 8'h55, 6'h3C, 1'b0, 4'd5, 1'b1, 1'b0, 5'h00, 1'b1},
        '{8'd13, 8'h55, 6'h00, 1'b0, 4'd0, 1'b1, 1'b1, 5'h00, 1'b1},
        '{8'd13, 8'h54, 6'h11, 1'b0, 4'd0, 1'b1, 1'b0, 5'h04, 1'b0},
        '{8'd13, 8'h55, 6'h11, 1'b1, 4'd0, 1'b1, 1'b0, 5'h08, 1'b0},
        '{8'd12, 8'h55, 6'h11, 1'b0, 4'd0, 1'b1, 1'b0, 5'h02, 1'b0},
        '{8'd8,  8'h55, 6'h11, 1'b0, 4'd0, 1'b1, 1'b0, 5'h00, 1'b0},
        '{8'd13, 8'h55, 6'h3F, 1'b0, 4'd0, 1'b0, 1'b0, 5'h01, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b0;
    logic        rx_in = 1'b1;
    logic [15:0] to_limit = 16'd192;
    logic [4:0]  err_clr = '0;
    logic [5:0]  frame_id;
    logic        hdr_valid;
    logic [4:0]  err_flags;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    int vcount = 0;
    logic [5:0] last_id = '0;
    logic [1:0] tdiv = '0;

    lin_hdr_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .rx_in    (rx_in),
        .to_limit (to_limit),
        .err_clr  (err_clr),
        .frame_id (frame_id),
        .hdr_valid(hdr_valid),
        .err_flags(err_flags),
        .irq      (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        tdiv     <= tdiv + 2'd1;
        smp_tick <= (tdiv == 2'd3);
    end

    always @(negedge clk) begin
        if (hdr_valid) begin
            vcount  = vcount + 1;
            last_id = frame_id;
        end
    end

    function automatic logic [7:0] pid_of(input logic [5:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R6 nominal header";
            1: return "R7 long break and gap";
            2: return "R8 glitch vote";
            3: return "R4 R11 sync";
            4: return "R5 parity";
            5: return "R2 short break";
            6: return "R1 low ignored";
            default: return "R3 stop bit";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int nclk);
        rx_in = lvl;
        repeat (nclk) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_ok, input logic glitch);
        drive(1'b0, BIT_CLK);
        for (int k = 0; k < 8; k++) begin
            if (glitch && k == 0) begin
                drive(b[k], 28);
                drive(~b[k], TICK_DIV);
                drive(b[k], BIT_CLK - 28 - TICK_DIV);
            end else begin
                drive(b[k], BIT_CLK);
            end
        end
        drive(stop_ok, BIT_CLK);
        rx_in = 1'b1;
    endtask

    task automatic clear_all();
        err_clr = 5'h1F;
        @(negedge clk);
        err_clr = 5'h00;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        check("R12 flags after reset", int'(err_flags), 0);
        check("R12 irq after reset", int'(irq), 0);
        check("R12 valid after reset", int'(hdr_valid), 0);
        check("R12 id after reset", int'(frame_id), 0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            int vb;
            logic [7:0] pid;
            v   = VECS[i];
            vb  = vcount;
            pid = pid_of(v.id) ^ (v.par_bad ? 8'h80 : 8'h00);
            drive(1'b1, 2 * BIT_CLK);
            drive(1'b0, int'(v.brk) * BIT_CLK);
            drive(1'b1, BIT_CLK);
            send_byte(v.sync, 1'b1, v.glitch);
            drive(1'b1, int'(v.gap) * BIT_CLK);
            send_byte(pid, v.stop_ok, 1'b0);
            drive(1'b1, 3 * BIT_CLK);
            check({tag_of(i), " flags"}, int'(err_flags), int'(v.exp_flags));
            check({tag_of(i), " valid count"}, vcount - vb, int'(v.exp_valid));
            check({tag_of(i), " irq"}, int'(irq), int'(v.exp_flags != 0));
            if (v.exp_valid) begin
                check({tag_of(i), " id"}, int'(last_id), int'(v.id));
            end
            if (v.exp_flags != 0) begin
                // R10 clearing other bits leaves the raised flag
                err_clr = ~v.exp_flags;
                @(negedge clk);
                err_clr = 5'h00;
                repeat (2) @(negedge clk);
                check("R10 sticky under other clears", int'(err_flags), int'(v.exp_flags));
                clear_all();
                check("R10 flag cleared", int'(err_flags), 0);
                check("R10 irq cleared", int'(irq), 0);
            end
        end

        // R9 timeout window
        drive(1'b1, 2 * BIT_CLK);
        drive(1'b0, 13 * BIT_CLK);
        drive(1'b1, 10 * BIT_CLK);
        check("R9 no timeout before limit", int'(err_flags), 0);
        drive(1'b1, 4 * BIT_CLK);
        check("R9 timeout flag", int'(err_flags), 5'h10);
        check("R9 timeout irq", int'(irq), 1);
        clear_all();

        // R9 limit zero disables, R7 late byte still accepted
        to_limit = 16'd0;
        begin
            int vb;
            vb = vcount;
            drive(1'b0, 13 * BIT_CLK);
            drive(1'b1, 20 * BIT_CLK);
            check("R9 disabled timeout", int'(err_flags), 0);
            send_byte(8'h55, 1'b1, 1'b0);
            drive(1'b1, 12 * BIT_CLK);
            send_byte(pid_of(6'h15), 1'b1, 1'b0);
            drive(1'b1, 3 * BIT_CLK);
            check("R7 untimed gap valid", vcount - vb, 1);
            check("R7 untimed gap id", int'(last_id), 6'h15);
            check("R7 untimed gap flags", int'(err_flags), 0);
        end
        to_limit = 16'd192;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule